// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block resolves conditional branches for a small processor pipeline. It does not keep flags. A compare strobe stores the two raw register values it is given. A later branch strobe names one of ten relations: equality, signed order or unsigned order. The block tests that relation on the stored pair only at that point, and it reports whether the branch is taken and which program counter follows.

The branch target is relative to the instruction that follows the branch. That address is the current PC plus the 2-byte instruction size. The displacement is a signed halfword count, so it reaches 512 halfwords behind and 511 halfwords ahead of that address. Condition codes outside the ten defined ones are reported as illegal, and the PC is held at the branch's own address so that an exception handler can see it.

All results are registered. They appear one clock after the branch strobe, with a one-cycle valid pulse, and they hold their values until the next branch.

Top module: `cmp_branch_unit`

## Requirements
- R1: A compare strobe (`cmp_valid`=1) with no branch strobe only stores `cmp_lhs` and `cmp_rhs`. In the following cycle `res_valid` is 0 and `taken`, `illegal` and `next_pc` keep their previous values.
- R2: `br_cond` selects the relation between the stored left operand A and the stored right operand B. The codes are: 0 A==B, 1 A!=B, 2 A<B signed, 3 A>B signed, 4 A<B unsigned, 5 A>B unsigned, 6 A>=B signed, 7 A<=B signed, 8 A>=B unsigned, 9 A<=B unsigned. `taken` is 1 when the relation holds.
- R3: For a legal code whose relation is false, `next_pc` = `cur_pc` + 2, taken modulo 2^32.
- R4: For a legal code whose relation is true, `next_pc` = `cur_pc` + 2 + 2 × (sign-extended 10-bit `br_disp`), modulo 2^32.
- R5: For codes 10 to 15, `illegal`=1, `taken`=0 and `next_pc` = `cur_pc`.
- R6: While reset is asserted and after reset, `res_valid`, `taken`, `illegal` and `next_pc` are 0, and both stored operands are 0. A first branch with code 0 is therefore taken.
- R7: When a compare strobe and a branch strobe arrive in the same cycle, the branch is evaluated against the operands stored before that cycle. The new operands serve later branches.
- R8: Results appear in the cycle after `br_valid`=1, with `res_valid`=1 for exactly that cycle. `res_valid` is 0 in the cycle after a cycle without a branch strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmp_valid | input | 1 | Compare strobe: store both operands |
| cmp_lhs | input | 32 | Left compare operand (A) |
| cmp_rhs | input | 32 | Right compare operand (B) |
| br_valid | input | 1 | Branch strobe |
| br_cond | input | 4 | Condition code |
| br_disp | input | 10 | Signed halfword displacement |
| cur_pc | input | 32 | Address of the branch instruction |
| res_valid | output | 1 | Result pulse, one cycle after `br_valid` |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Address that follows the branch |
| illegal | output | 1 | Undefined condition code |

## Verification
The bench builds the block with its default widths: 32-bit operands and PC, and a 10-bit displacement. At these widths the largest forward displacement (0x1FF) and the largest backward one (0x200) can be driven directly. So can PC values near the top of the address space, where the sum wraps to zero. Random operands are biased toward equal pairs and toward pairs whose sign bits differ. This is where the signed and unsigned orders disagree, so every condition code is tested across that split.

// File: rtl/cmp_branch_pkg.sv
package cmp_branch_pkg;
  localparam int unsigned COND_W    = 4;
  localparam int unsigned NUM_CONDS = 10;

  typedef enum logic [COND_W-1:0] {
    CND_EQ  = 4'd0,
    CND_NE  = 4'd1,
    CND_LT  = 4'd2,
    CND_GT  = 4'd3,
    CND_LTU = 4'd4,
    CND_GTU = 4'd5,
    CND_GE  = 4'd6,
    CND_LE  = 4'd7,
    CND_GEU = 4'd8,
    CND_LEU = 4'd9
  } cond_e;
endpackage

// File: rtl/cmp_operand_latch.sv
module cmp_operand_latch #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] lhs_in,
  input  logic [DATA_W-1:0] rhs_in,
  output logic [DATA_W-1:0] lhs_q,
  output logic [DATA_W-1:0] rhs_q
);
  logic [DATA_W-1:0] lhs_d, rhs_d;

  always_comb begin
    lhs_d = lhs_q;
    rhs_d = rhs_q;
    if (cap_en) begin
      lhs_d = lhs_in;
      rhs_d = rhs_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lhs_q <= '0;
      rhs_q <= '0;
    end else if (cap_en) begin
      lhs_q <= lhs_d;
      rhs_q <= rhs_d;
    end
  end

  // Stored operands change only on a compare strobe (R1).
  p_operands_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(lhs_q) && $stable(rhs_q)));

  // A capture takes exactly the offered values (R1).
  p_operands_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (lhs_q == $past(lhs_in) && rhs_q == $past(rhs_in)));
endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
  import cmp_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [COND_W-1:0] cond,
  output logic              hit,
  output logic              bad
);
  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (opa == opb);
    lt_s = ($signed(opa) < $signed(opb));
    lt_u = (opa < opb);
  end

  always_comb begin
    hit = 1'b0;
    bad = 1'b0;
    case (cond)
      CND_EQ:  hit = eq;
      CND_NE:  hit = !eq;
      CND_LT:  hit = lt_s;
      CND_GT:  hit = !lt_s && !eq;
      CND_LTU: hit = lt_u;
      CND_GTU: hit = !lt_u && !eq;
      CND_GE:  hit = !lt_s;
      CND_LE:  hit = lt_s || eq;
      CND_GEU: hit = !lt_u;
      CND_LEU: hit = lt_u || eq;
      default: bad = 1'b1;
    endcase
  end

  // An undefined code never reports a satisfied relation (R5).
  always_comb begin
    a_bad_no_hit_r5: assert (!(bad && hit));
  end
endmodule

// File: rtl/cmp_target_calc.sv
module cmp_target_calc #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DISP_W = 10,
  parameter int unsigned STEP   = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc
);
  localparam int unsigned EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] disp_bytes;

  always_comb begin
    disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
    disp_bytes = disp_ext << 1;
    seq_pc     = pc + PC_W'(STEP);
    tgt_pc     = seq_pc + disp_bytes;
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cmp_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DISP_W = 10,
  parameter int unsigned STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_lhs,
  input  logic [DATA_W-1:0] cmp_rhs,
  input  logic              br_valid,
  input  logic [3:0]        br_cond,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              res_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              illegal
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DATA_W-1:0] opa_q, opb_q;
  logic              cond_hit, cond_bad;
  logic [PC_W-1:0]   seq_pc, tgt_pc;

  cmp_operand_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (cmp_valid),
    .lhs_in (cmp_lhs),
    .rhs_in (cmp_rhs),
    .lhs_q  (opa_q),
    .rhs_q  (opb_q)
  );

  cmp_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .opa  (opa_q),
    .opb  (opb_q),
    .cond (br_cond),
    .hit  (cond_hit),
    .bad  (cond_bad)
  );

  cmp_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .STEP(STEP)) u_tgt (
    .pc     (cur_pc),
    .disp   (br_disp),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  logic            taken_d, illegal_d;
  logic [PC_W-1:0] next_pc_d;

  always_comb begin
    taken_d   = taken;
    illegal_d = illegal;
    next_pc_d = next_pc;
    if (br_valid) begin
      taken_d   = cond_hit && !cond_bad;
      illegal_d = cond_bad;
      if (cond_bad)      next_pc_d = cur_pc;
      else if (cond_hit) next_pc_d = tgt_pc;
      else               next_pc_d = seq_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      next_pc   <= '0;
    end else begin
      res_valid <= br_valid;
      if (br_valid) begin
        taken   <= taken_d;
        illegal <= illegal_d;
        next_pc <= next_pc_d;
      end
    end
  end

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_valid |=> res_valid);

  p_valid_only_after_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !br_valid |=> !res_valid);

  p_cmp_only_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_valid && !br_valid) |=> ($stable(next_pc) && $stable(taken) && $stable(illegal)));

  p_illegal_holds_pc_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_valid && br_cond >= 4'(NUM_CONDS)) |=>
      (illegal && !taken && next_pc == $past(cur_pc)));

  p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && !taken && !illegal) |-> (next_pc == $past(cur_pc) + PC_W'(STEP)));

  p_taken_legal_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> !(taken && illegal));
endmodule

// File: tb/cmp_branch_unit_tb_top.sv
module cmp_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid;
  logic [31:0] cmp_lhs, cmp_rhs;
  logic        br_valid;
  logic [3:0]  br_cond;
  logic [9:0]  br_disp;
  logic [31:0] cur_pc;
  logic        res_valid, taken, illegal;
  logic [31:0] next_pc;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] mdl_a = 0, mdl_b = 0;

  always #2.5 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .br_valid(br_valid), .br_cond(br_cond), .br_disp(br_disp), .cur_pc(cur_pc),
    .res_valid(res_valid), .taken(taken), .next_pc(next_pc), .illegal(illegal)
  );

  function automatic bit rel_holds(int c, logic [31:0] a, logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return sa < sb;
      3: return sa > sb;
      4: return a < b;
      5: return a > b;
      6: return sa >= sb;
      7: return sa <= sb;
      8: return a >= b;
      9: return a <= b;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_pc(int c, logic [9:0] d, logic [31:0] pc,
                                        logic [31:0] a, logic [31:0] b);
    int off;
    if (c > 9) return pc;
    off = d[9] ? int'(d) - 1024 : int'(d);
    if (rel_holds(c, a, b)) return pc + 32'd2 + 32'(off * 2);
    return pc + 32'd2;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmp_valid = 0; br_valid = 0;
  endtask

  task automatic do_cmp(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1; cmp_lhs = a; cmp_rhs = b; br_valid = 0;
    mdl_a = a; mdl_b = b;
    @(negedge clk);
    idle();
  endtask

  // Branch, optionally with a simultaneous compare; checks the result.
  task automatic do_br(int c, logic [9:0] d, logic [31:0] pc, string req,
                       bit with_cmp = 0, logic [31:0] na = 0, logic [31:0] nb = 0);
    logic [31:0] epc;
    bit et, ei;
    @(negedge clk);
    br_valid = 1; br_cond = 4'(c); br_disp = d; cur_pc = pc;
    cmp_valid = with_cmp; cmp_lhs = na; cmp_rhs = nb;
    epc = exp_pc(c, d, pc, mdl_a, mdl_b);
    et  = (c <= 9) && rel_holds(c, mdl_a, mdl_b);
    ei  = (c > 9);
    if (with_cmp) begin mdl_a = na; mdl_b = nb; end
    @(negedge clk);
    idle();
    check(res_valid === 1'b1, {req, " res_valid"}, 32'(res_valid), 1);
    check(taken === et, {req, " taken"}, 32'(taken), 32'(et));
    check(illegal === ei, {req, " illegal"}, 32'(illegal), 32'(ei));
    check(next_pc === epc, {req, " next_pc"}, next_pc, epc);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 4))
      0: return 32'h8000_0000 | $urandom_range(0, 3);
      1: return $urandom_range(0, 3);
      2: return 32'hFFFF_FFFF - $urandom_range(0, 3);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] hold_pc;
    bit hold_t, hold_i;
    void'($urandom(32'd1234));
    rst_n = 0; idle(); cmp_lhs = 0; cmp_rhs = 0; br_cond = 0; br_disp = 0; cur_pc = 0;
    repeat (3) @(negedge clk);
    // R6: reset state
    check(res_valid === 0 && taken === 0 && illegal === 0, "R6 flags in reset",
          {29'b0, res_valid, taken, illegal}, 0);
    check(next_pc === 0, "R6 next_pc in reset", next_pc, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(res_valid === 0 && next_pc === 0, "R6 after release", next_pc, 0);
    // R6: operands zero -> equal taken; R4 forward max
    do_br(0, 10'h1FF, 32'h0000_1000, "R6 R4 eq on reset operands");
    // R8: quiet cycle drops valid, holds outputs
    @(negedge clk);
    check(res_valid === 0, "R8 valid single pulse", 32'(res_valid), 0);
    check(next_pc === 32'h0000_1400, "R8 hold next_pc", next_pc, 32'h0000_1400);

    // R1: compare alone changes nothing visible
    hold_pc = next_pc; hold_t = taken; hold_i = illegal;
    do_cmp(32'h8000_0000, 32'h0000_0001);
    check(res_valid === 0, "R1 no valid after compare", 32'(res_valid), 0);
    check(next_pc === hold_pc && taken === hold_t && illegal === hold_i,
          "R1 outputs unchanged", next_pc, hold_pc);

    // R2: every code on a sign-split pair, then on equal pair
    for (int c = 0; c < 10; c++) do_br(c, 10'h010, 32'h0000_2000, "R2 split");
    do_cmp(32'h1234_5678, 32'h1234_5678);
    for (int c = 0; c < 10; c++) do_br(c, 10'h3F0, 32'h0000_3000, "R2 equal");

    // R4: backward max; R3/R4 wrap near top of space
    do_br(0, 10'h200, 32'h0000_0800, "R4 backward max");
    do_br(1, 10'h005, 32'hFFFF_FFFE, "R3 wrap fallthrough");
    do_br(0, 10'h001, 32'hFFFF_FFFC, "R4 wrap taken");

    // R5: all undefined codes
    for (int c = 10; c < 16; c++) do_br(c, 10'h0AA, 32'h0000_5000 + 32'(c), "R5 illegal");

    // R7: same-cycle compare and branch
    do_cmp(32'd5, 32'd5);
    do_br(0, 10'h004, 32'h0000_6000, "R7 old operands", 1, 32'd1, 32'd9);
    do_br(4, 10'h004, 32'h0000_6100, "R7 new operands used later");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) != 0) begin
        logic [31:0] a, b;
        a = pick_val();
        b = ($urandom_range(0, 3) == 0) ? a : pick_val();
        if ($urandom_range(0, 4) == 0)
          do_br($urandom_range(0, 15), 10'($urandom), $urandom, "R7 R2 random dual", 1, a, b);
        else
          do_cmp(a, b);
      end
      do_br($urandom_range(0, 15), 10'($urandom), $urandom, "R2 R3 R4 R5 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule